// File: doc/BRIEF.md
# Multi-format serial audio transceiver

This block is a frame-based stereo audio port. It moves samples between parallel per-lane registers and a set of serial data lanes: three input lanes and three output lanes by default. All lanes share one bit clock and one word clock, and an external device drives both. The bit clock and word clock are oversampled in the system clock domain. Input data is sampled on a detected rising bit-clock edge, and output data changes after a detected falling edge.

Three runtime settings choose how a frame is laid out. The first picks the justification: I2S, left-justified or right-justified. The second picks the frame length, 32 or 64 bit clocks. The third picks the sample width inside a 64-clock frame.

Each lane collects a left word and a right word. When the right channel of a frame closes, the block updates all lanes' receive words together and raises a one-cycle strobe. Transmit words are taken from the parallel inputs into holding registers at the start of each frame and shifted out MSB first.

Top module: `audio_serial_port`

## Requirements
- R1: With `fmt_sel`=1 (left-justified), a channel's MSB occupies the first bit clock after a word-clock change, and word clock high marks the left channel. `fmt_sel`=3 behaves the same way.
- R2: With `fmt_sel`=0 (I2S), the MSB occupies the second bit clock after a word-clock change, and word clock low marks the left channel.
- R3: With `fmt_sel`=2 (right-justified), a channel's LSB occupies the last bit clock before the next word-clock change, so the MSB position moves with the word length.
- R4: With `frame_long`=0, each channel has 16 bit clocks and carries a 16-bit word, whatever the value of `word_sel`.
- R5: With `frame_long`=1, each channel has 32 bit clocks, and `word_sel` 0/1/2/3 selects a word length of 16/18/20/24 bits.
- R6: Slot positions outside the word are driven 0 on `sd_out` and ignored on `sd_in`. Transmit bits above the word length are ignored. Receive words are right-aligned in bits [W-1:0] with zeros above.
- R7: `rx_strobe` is high for exactly one cycle per frame, in the cycle in which the left and right words of every lane update together. This happens after the right channel ends.
- R8: Transmit words are taken from `tx_left`/`tx_right` at the falling bit-clock edge that starts a frame. Changing them during a frame affects only the following frame.
- R9: `sd_out` changes only after a falling bit-clock edge, and holds its value across the rising edge on which a receiver samples it.
- R10: Lane i uses bits [24i+23:24i] of each parallel bus, and lanes run independently with different data.
- R11: After reset, `sd_out`, `rx_left`, `rx_right` and `rx_strobe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| frame_long | input | 1 | 1: 64 bit clocks per frame, 0: 32 |
| word_sel | input | 2 | Word length in long frames: 16, 18, 20, 24 |
| bclk | input | 1 | Shared serial bit clock |
| wclk | input | 1 | Shared word (left/right) clock |
| sd_in | input | LANES | Serial input lanes |
| sd_out | output | LANES | Serial output lanes |
| tx_left | input | LANES*WMAX | Left transmit words, right-aligned |
| tx_right | input | LANES*WMAX | Right transmit words, right-aligned |
| rx_left | output | LANES*WMAX | Received left words, right-aligned |
| rx_right | output | LANES*WMAX | Received right words, right-aligned |
| rx_strobe | output | 1 | One-cycle pulse on each completed frame |

## Verification
One rising bit-clock edge does two jobs. It closes the right channel, which publishes the finished frame and raises the strobe. In the same cycle it restarts the shifter with the first bit of the next left word. The bench provokes this collision by sending frames back to back in the modes where slot position 0 carries data (left-justified and right-justified full-width). Each frame is paired with its strobe through a queue, so a bit that is lost or duplicated at the boundary shows up as a mismatched word. The transmit load at the frame start is tested alongside it: the transmit inputs are changed part-way through a frame, and the serial output of that frame and of the next one are both compared.

// File: rtl/asp_pkg.sv
package asp_pkg;

  localparam int POS_W = 6;
  localparam int IDX_W = 5;

  localparam logic [1:0] FMT_I2S = 2'd0;
  localparam logic [1:0] FMT_LJ  = 2'd1;
  localparam logic [1:0] FMT_RJ  = 2'd2;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } slot_t;

  function automatic logic [IDX_W-1:0] word_len(logic flong, logic [1:0] wsel);
    if (!flong) return 5'd16;
    case (wsel)
      2'd0:    return 5'd16;
      2'd1:    return 5'd18;
      2'd2:    return 5'd20;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [POS_W-1:0] slot_len(logic flong);
    return flong ? 6'd32 : 6'd16;
  endfunction

  // Map a slot position to a data bit index, given the format settings.
  function automatic slot_t map_slot(logic [1:0] fmt, logic flong, logic [1:0] wsel,
                                     logic [POS_W-1:0] pos);
    slot_t            r;
    logic [POS_W-1:0] w, s, o, k;
    w = {1'b0, word_len(flong, wsel)};
    s = slot_len(flong);
    o = (fmt == FMT_RJ) ? (s - w) : 6'd0;
    k = pos - o;
    r.hit = (pos >= o) && (k < w);
    r.idx = IDX_W'(w - 6'd1 - k);
    return r;
  endfunction

endpackage

// File: rtl/asp_timing.sv
module asp_timing
  import asp_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             wclk,
  input  logic [LANES-1:0] sd_in,
  input  logic [1:0]       fmt_sel,
  input  logic             frame_long,
  output logic             rise,
  output logic             fall,
  output logic             chg,
  output logic             ch_end,
  output logic [POS_W-1:0] pos_now,
  output logic [POS_W-1:0] tx_pos,
  output logic             tx_ch,
  output logic             tx_start,
  output logic [LANES-1:0] sd_s,
  output logic             strobe
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             bclk_s, bclk_p, wclk_s, lr_dly_q, ch_q, strobe_q;
  logic [POS_W-1:0] pos_q;
  logic [LANES-1:0] sd_q;
  logic             lr_eff, ch_now, at_end, strobe_n;
  logic [POS_W-1:0] pos_inc;

  always_comb begin
    rise    = bclk_s & ~bclk_p;
    fall    = ~bclk_s & bclk_p;
    // I2S is left-justified against a word clock delayed by one bit
    lr_eff  = (fmt_sel == FMT_I2S) ? lr_dly_q : wclk_s;
    ch_now  = (fmt_sel == FMT_I2S) ? lr_eff : ~lr_eff;
    chg     = rise & (ch_now != ch_q);
    pos_inc = (pos_q == POS_MAX) ? POS_MAX : pos_q + 6'd1;
    pos_now = chg ? '0 : pos_inc;
    at_end  = (pos_q == slot_len(frame_long) - 6'd1);
    tx_pos  = at_end ? '0 : pos_inc;
    tx_ch   = at_end ? ~ch_q : ch_q;
    tx_start = fall & at_end & ch_q;
    strobe_n = chg & ch_q;
    ch_end  = ch_q;
    sd_s    = sd_q;
    strobe  = strobe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_s   <= 1'b0;
      bclk_p   <= 1'b0;
      wclk_s   <= 1'b0;
      sd_q     <= '0;
      lr_dly_q <= 1'b0;
      ch_q     <= 1'b0;
      pos_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      bclk_s   <= bclk;
      bclk_p   <= bclk_s;
      wclk_s   <= wclk;
      sd_q     <= sd_in;
      strobe_q <= strobe_n;
      if (rise) begin
        lr_dly_q <= wclk_s;
        ch_q     <= ch_now;
        pos_q    <= pos_now;
      end
    end
  end

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
  assert_strobe_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> !ch_q);
  assert_pos_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chg) |-> (pos_q == '0));

endmodule

// File: rtl/asp_rx_lane.sv
module asp_rx_lane
  import asp_pkg::*;
#(
  parameter int WMAX = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rise,
  input  logic            chg,
  input  logic            ch_end,
  input  logic            hit,
  input  logic            sd,
  output logic [WMAX-1:0] word_l,
  output logic [WMAX-1:0] word_r
);

  logic [WMAX-1:0] sh_q, stage_q, out_l_q, out_r_q;
  logic [WMAX-1:0] sh_n, stage_n, out_l_n, out_r_n;

  always_comb begin
    sh_n    = sh_q;
    stage_n = stage_q;
    out_l_n = out_l_q;
    out_r_n = out_r_q;
    if (chg) begin
      sh_n = hit ? {{(WMAX-1){1'b0}}, sd} : '0;
      if (!ch_end) begin
        stage_n = sh_q;
      end else begin
        out_l_n = stage_q;
        out_r_n = sh_q;
      end
    end else if (hit) begin
      sh_n = {sh_q[WMAX-2:0], sd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      stage_q <= '0;
      out_l_q <= '0;
      out_r_q <= '0;
    end else if (rise) begin
      sh_q    <= sh_n;
      stage_q <= stage_n;
      out_l_q <= out_l_n;
      out_r_q <= out_r_n;
    end
  end

  assign word_l = out_l_q;
  assign word_r = out_r_q;

  assert_rx_update_on_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(chg & ch_end) |-> ($stable(out_l_q) && $stable(out_r_q)));

endmodule

// File: rtl/asp_tx_lane.sv
module asp_tx_lane
  import asp_pkg::*;
#(
  parameter int WMAX = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             tx_start,
  input  logic             tx_ch,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  input  logic [WMAX-1:0]  in_l,
  input  logic [WMAX-1:0]  in_r,
  output logic             sd
);

  logic [WMAX-1:0] hold_l_q, hold_r_q, word;
  logic            sd_q, sd_n;

  always_comb begin
    if (tx_ch) word = hold_r_q;
    else       word = tx_start ? in_l : hold_l_q;
    sd_n = hit ? word[idx] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      sd_q     <= 1'b0;
    end else begin
      if (tx_start) begin
        hold_l_q <= in_l;
        hold_r_q <= in_r;
      end
      if (fall) sd_q <= sd_n;
    end
  end

  assign sd = sd_q;

  assert_sdo_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fall) |-> $stable(sd_q));
  assert_hold_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fall) |-> ($stable(hold_l_q) && $stable(hold_r_q)));

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int LANES = 3,
  parameter int WMAX  = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            fmt_sel,
  input  logic                  frame_long,
  input  logic [1:0]            word_sel,
  input  logic                  bclk,
  input  logic                  wclk,
  input  logic [LANES-1:0]      sd_in,
  output logic [LANES-1:0]      sd_out,
  input  logic [LANES*WMAX-1:0] tx_left,
  input  logic [LANES*WMAX-1:0] tx_right,
  output logic [LANES*WMAX-1:0] rx_left,
  output logic [LANES*WMAX-1:0] rx_right,
  output logic                  rx_strobe
);

  logic [1:0]       rst_sync;
  logic             rst_ni;
  logic             rise, fall, chg, ch_end, tx_ch, tx_start;
  logic [POS_W-1:0] pos_now, tx_pos;
  logic [LANES-1:0] sd_s;
  slot_t            rx_map, tx_map;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  asp_timing #(.LANES(LANES)) u_timing (
    .clk(clk), .rst_n(rst_ni), .bclk(bclk), .wclk(wclk), .sd_in(sd_in),
    .fmt_sel(fmt_sel), .frame_long(frame_long),
    .rise(rise), .fall(fall), .chg(chg), .ch_end(ch_end), .pos_now(pos_now),
    .tx_pos(tx_pos), .tx_ch(tx_ch), .tx_start(tx_start), .sd_s(sd_s),
    .strobe(rx_strobe)
  );

  always_comb begin
    rx_map = map_slot(fmt_sel, frame_long, word_sel, pos_now);
    tx_map = map_slot(fmt_sel, frame_long, word_sel, tx_pos);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    asp_rx_lane #(.WMAX(WMAX)) u_rx (
      .clk(clk), .rst_n(rst_ni), .rise(rise), .chg(chg), .ch_end(ch_end),
      .hit(rx_map.hit), .sd(sd_s[i]),
      .word_l(rx_left[i*WMAX +: WMAX]), .word_r(rx_right[i*WMAX +: WMAX])
    );
    asp_tx_lane #(.WMAX(WMAX)) u_tx (
      .clk(clk), .rst_n(rst_ni), .fall(fall), .tx_start(tx_start), .tx_ch(tx_ch),
      .hit(tx_map.hit), .idx(tx_map.idx),
      .in_l(tx_left[i*WMAX +: WMAX]), .in_r(tx_right[i*WMAX +: WMAX]),
      .sd(sd_out[i])
    );
  end

endmodule

// File: tb/audio_serial_port_tb.sv
module audio_serial_port_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt_r, wsel_r;
  logic        flong_r;
  logic        bclk, wclk;
  logic [2:0]  sd_in, sd_out;
  logic [71:0] tx_left, tx_right, rx_left, rx_right;
  logic        rx_strobe;
  int          tests = 0;
  int          fails = 0;
  bit          done = 0;

  typedef struct {
    bit          ck;
    logic [71:0] l;
    logic [71:0] r;
    string       req;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  audio_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_r), .frame_long(flong_r), .word_sel(wsel_r),
    .bclk(bclk), .wclk(wclk), .sd_in(sd_in), .sd_out(sd_out),
    .tx_left(tx_left), .tx_right(tx_right), .rx_left(rx_left), .rx_right(rx_right),
    .rx_strobe(rx_strobe)
  );

  task automatic chk(bit ok, string req, string what, logic [71:0] act, logic [71:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int wl();
    if (!flong_r) return 16;
    case (wsel_r)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic sbit(logic [23:0] w, int p, logic fill);
    int s = flong_r ? 32 : 16;
    int n = wl();
    int o = (fmt_r == 2'd2) ? s - n : 0;
    if (p >= o && p - o < n) return w[n-1-(p-o)];
    return fill;
  endfunction

  function automatic logic [71:0] msk(logic [71:0] v);
    logic [23:0] m = (24'd1 << wl()) - 24'd1;
    return v & {m, m, m};
  endfunction

  // driver: one frame on the serial side, expected receive words into the queue
  task automatic run_frame(bit ck, logic [71:0] l, logic [71:0] r, int mid, string req);
    int s = flong_r ? 32 : 16;
    logic [71:0] tl = tx_left;
    logic [71:0] tr = tx_right;
    int errs [3] = '{0, 0, 0};
    logic [2:0] first_act = '0, first_exp = '0;
    q.push_back('{ck, msk(l), msk(r), req});
    for (int t = 0; t < 2*s; t++) begin
      bit ch = (t >= s);
      int p = t % s;
      @(negedge clk);
      bclk = 1'b0;
      wclk = (fmt_r == 2'd0) ? (((t+1) % (2*s)) >= s) : (t < s);
      for (int i = 0; i < 3; i++) sd_in[i] = sbit(ch ? r[i*24 +: 24] : l[i*24 +: 24], p, 1'b1);
      if (t == mid) begin
        tx_left  = ~tx_left;
        tx_right = ~tx_right;
      end
      repeat (3) @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        for (int i = 0; i < 3; i++) begin
          logic e = sbit(ch ? tr[i*24 +: 24] : tl[i*24 +: 24], p, 1'b0);
          if (sd_out[i] !== e) begin
            if (errs[i] == 0) begin first_act[i] = sd_out[i]; first_exp[i] = e; end
            errs[i]++;
          end
        end
        if (k == 0) begin
          @(negedge clk);
          bclk = 1'b1;
          repeat (3) @(negedge clk);
        end
      end
    end
    if (ck)
      for (int i = 0; i < 3; i++)
        chk(errs[i] == 0, {req, " R9 R10"}, $sformatf("sd_out lane %0d bit", i),
            72'(first_act[i]), 72'(first_exp[i]));
  endtask

  task automatic cfg(logic [1:0] f, logic fl, logic [1:0] w);
    fmt_r = f; flong_r = fl; wsel_r = w;
  endtask

  function automatic logic [71:0] pat(int k);
    return {24'h9A3C71 + 24'(k * 4099), 24'h5E0F2B ^ 24'(k * 257), 24'hC0FFEE - 24'(k * 131)};
  endfunction

  task automatic block(logic [1:0] f, logic fl, logic [1:0] w, int seed, string req);
    cfg(f, fl, w);
    tx_left  = pat(seed + 7);
    tx_right = ~pat(seed + 9);
    run_frame(0, pat(seed), ~pat(seed + 1), -1, req);
    for (int n = 1; n < 3; n++) begin
      tx_left  = pat(seed + 20 + n);
      tx_right = pat(seed + 40 + n) ^ 72'h00F0F0_0F0F0F_FF00FF;
      run_frame(1, pat(seed + 3*n), pat(seed + 3*n + 1) ^ 72'hFFFFFF_000000_A5A5A5, -1, req);
    end
  endtask

  // monitor: pop one expectation per strobe and compare
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n === 1'b1 && rx_strobe === 1'b1) begin
      if (q.size() == 0) chk(0, "R7", "strobe with no frame pending", 72'd1, 72'd0);
      else begin
        e = q.pop_front();
        if (e.ck) begin
          chk(rx_left === e.l, {e.req, " R7 R10"}, "rx_left", rx_left, e.l);
          chk(rx_right === e.r, {e.req, " R7 R10"}, "rx_right", rx_right, e.r);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bclk = 1'b0; wclk = 1'b0; sd_in = '0;
    tx_left = '0; tx_right = '0;
    cfg(2'd1, 1'b1, 2'd3);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state at the ports
    chk(sd_out === 3'b000, "R11", "sd_out after reset", 72'(sd_out), 72'd0);
    chk(rx_strobe === 1'b0, "R11", "rx_strobe after reset", 72'(rx_strobe), 72'd0);
    chk(rx_left === '0 && rx_right === '0, "R11", "rx words after reset", rx_left | rx_right, 72'd0);

    block(2'd1, 1'b1, 2'd3, 10, "R1 R5");    // left-justified, 24-bit
    block(2'd0, 1'b1, 2'd3, 30, "R2 R5");    // I2S, 24-bit
    block(2'd2, 1'b1, 2'd3, 50, "R3 R5");    // right-justified, 24-bit
    block(2'd2, 1'b1, 2'd1, 70, "R3 R6");    // right-justified, 18-bit
    block(2'd1, 1'b1, 2'd2, 90, "R5 R6");    // left-justified, 20-bit
    block(2'd0, 1'b1, 2'd0, 110, "R2 R5 R6"); // I2S, 16-bit in long frame
    block(2'd3, 1'b1, 2'd3, 130, "R1");      // code 3 acts as left-justified
    block(2'd1, 1'b0, 2'd3, 150, "R4");      // short frames ignore word_sel
    block(2'd0, 1'b0, 2'd2, 170, "R4");
    block(2'd2, 1'b0, 2'd1, 190, "R4 R3");

    // R8: transmit inputs change mid-frame; this frame keeps the old words
    cfg(2'd1, 1'b1, 2'd3);
    tx_left = pat(300); tx_right = pat(301);
    run_frame(0, pat(302), pat(303), -1, "R8");
    tx_left = pat(304); tx_right = pat(305);
    run_frame(1, pat(306), pat(307), 10, "R8");
    run_frame(1, pat(308), pat(309), -1, "R8");

    // flush: the last frame's strobe arrives at this frame's start
    run_frame(0, '0, '0, -1, "R7");
    repeat (10) @(negedge clk);
    chk(q.size() == 1, "R7", "one strobe per frame, pending count", 72'(q.size()), 72'd1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule